// File: doc/BRIEF.md
# Host-to-DMA Word FIFO Bridge with Group Request

This block sits between a host processor and one DMA channel of a second processor. The host first sets a transfer-enable bit. It then loads the number of 16-bit words it intends to move, and pushes those words one at a time into a small FIFO. While the buffered count is a non-zero multiple of four, the bridge holds a request line toward the DMA channel. The DMA side pops words one at a time from the head of the FIFO.

Every accepted pop decrements a remaining-length register. When that length reaches zero, the transfer-enable bit clears by itself, and later pushes are refused. A push made while the enable is clear is dropped and raises a one-cycle error pulse. A push into a full FIFO is also dropped. Status outputs give the full flag, the occupancy, the remaining length and the enable bit, so the host can pace its writes.

Top module: `dreq_fifo_bridge`

## Requirements
- R1: After reset, fifo_count, len_remaining, xfer_en, fifo_full, dma_dreq and push_err are all zero.
- R2: A host_push while xfer_en is 0 stores nothing, leaves fifo_count unchanged, and drives push_err to 1 for the following cycle only.
- R3: fifo_full is 1 exactly when fifo_count equals DEPTH (default 8). A host_push while full is dropped, and fifo_count never exceeds DEPTH.
- R4: dma_dreq is 1 exactly when fifo_count is non-zero and a multiple of 4. It follows every push and pop in the cycle after the clock edge.
- R5: dma_data presents the oldest buffered word. Each accepted pop advances to the next word in push order.
- R6: A host_len_wr loads len_remaining. Each accepted pop decrements it by one, saturating at zero.
- R7: When an accepted pop takes len_remaining from 1 to 0, xfer_en becomes 0, unless host_en_wr is given in the same cycle.
- R8: A dma_pop is ignored when the FIFO is empty or dma_tc_zero is 1. Count, length and head are left unchanged.
- R9: An accepted push and an accepted pop in the same cycle leave fifo_count unchanged. The new word goes behind all older words.
- R10: Any accepted pop clears fifo_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en_wr | input | 1 | Write strobe for the transfer-enable bit |
| host_en_val | input | 1 | Value written to the transfer-enable bit |
| host_len_wr | input | 1 | Write strobe for the length register |
| host_len_val | input | LEN_W | Word count to load |
| host_push | input | 1 | Push host_data into the FIFO |
| host_data | input | 16 | Word to push |
| dma_pop | input | 1 | DMA side consumes the head word |
| dma_tc_zero | input | 1 | DMA channel's own count is exhausted; blocks pops |
| dma_data | output | 16 | Head word of the FIFO |
| dma_dreq | output | 1 | Request: occupancy is a non-zero multiple of four |
| fifo_full | output | 1 | Occupancy equals DEPTH |
| fifo_count | output | CNT_W | Number of buffered words |
| xfer_en | output | 1 | Transfer-enable bit |
| len_remaining | output | LEN_W | Words still to be consumed |
| push_err | output | 1 | Pulse: push refused because enable was clear |

## Verification
Every result of this block is due one clock edge after its stimulus. Pushes, pops and register writes all land in registers at that edge. The request, full flag and head word are decoded from those registers with no further delay, and the error pulse is itself a register loaded on that edge. The bench therefore changes inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Each table row and each directed step compares count, request, full, head and length at that single point.

// File: rtl/dreq_bridge_pkg.sv
package dreq_bridge_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned GROUP  = 4;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dreq_shift_fifo.sv
module dreq_shift_fifo
  import dreq_bridge_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  word_t            push_word,
  output word_t            head_word,
  output logic [CNT_W-1:0] occ
);
  logic [DEPTH-1:0][WORD_W-1:0] slot_bus;
  logic [CNT_W-1:0]             occ_q, occ_d;

  // occupancy next-state
  always_comb begin
    occ_d = occ_q;
    if (push_ok && !pop_ok)      occ_d = occ_q + CNT_W'(1);
    else if (pop_ok && !push_ok) occ_d = occ_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                occ_q <= '0;
    else if (push_ok || pop_ok) occ_q <= occ_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    word_t q, d, above;
    logic  en;

    if (i < DEPTH - 1) begin : g_mid
      assign above = word_t'(slot_bus[i+1]);
    end else begin : g_top
      assign above = q;
    end

    always_comb begin
      d  = q;
      en = 1'b0;
      if (pop_ok) begin
        en = 1'b1;
        d  = above;
        if (push_ok && (occ_q == CNT_W'(i + 1))) d = push_word;
      end else if (push_ok && (occ_q == CNT_W'(i))) begin
        en = 1'b1;
        d  = push_word;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign slot_bus[i] = q;
  end

  assign head_word = word_t'(slot_bus[0]);
  assign occ       = occ_q;
endmodule

// File: rtl/dreq_len_ctrl.sv
module dreq_len_ctrl #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_val,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             push_req,
  input  logic             pop_ok,
  output logic             en_out,
  output logic [LEN_W-1:0] len_out,
  output logic             err_out
);
  logic             en_q, en_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             err_q, err_d;
  logic             len_nz, last_word;

  assign len_nz    = (len_q != '0);
  assign last_word = pop_ok && (len_q == LEN_W'(1)) && !len_wr;

  always_comb begin
    len_d = len_q;
    if (len_wr)                len_d = len_val;
    else if (pop_ok && len_nz) len_d = len_q - LEN_W'(1);
  end

  always_comb begin
    en_d = en_q;
    if (en_wr)          en_d = en_val;
    else if (last_word) en_d = 1'b0;
  end

  assign err_d = push_req && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      len_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (en_wr || last_word)         en_q  <= en_d;
      if (len_wr || (pop_ok && len_nz)) len_q <= len_d;
      err_q <= err_d;
    end
  end

  assign en_out  = en_q;
  assign len_out = len_q;
  assign err_out = err_q;
endmodule

// File: rtl/dreq_flag_decode.sv
module dreq_flag_decode
  import dreq_bridge_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] occ,
  output logic             full,
  output logic             empty,
  output logic             group_ready
);
  assign full        = (occ == CNT_W'(DEPTH));
  assign empty       = (occ == '0);
  assign group_ready = !empty && ((occ % CNT_W'(GROUP)) == '0);
endmodule

// File: rtl/dreq_fifo_bridge.sv
module dreq_fifo_bridge
  import dreq_bridge_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LEN_W = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_en_wr,
  input  logic             host_en_val,
  input  logic             host_len_wr,
  input  logic [LEN_W-1:0] host_len_val,
  input  logic             host_push,
  input  logic [15:0]      host_data,
  input  logic             dma_pop,
  input  logic             dma_tc_zero,
  output logic [15:0]      dma_data,
  output logic             dma_dreq,
  output logic             fifo_full,
  output logic [CNT_W-1:0] fifo_count,
  output logic             xfer_en,
  output logic [LEN_W-1:0] len_remaining,
  output logic             push_err
);
  logic             full_w, empty_w, group_w, push_ok, pop_ok, en_w;
  logic [CNT_W-1:0] occ_w;
  word_t            head_w;

  assign push_ok = host_push && en_w && !full_w;
  assign pop_ok  = dma_pop && !dma_tc_zero && !empty_w;

  dreq_shift_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .push_word (word_t'(host_data)),
    .head_word (head_w),
    .occ       (occ_w)
  );

  dreq_flag_decode #(.DEPTH(DEPTH)) u_flags (
    .occ         (occ_w),
    .full        (full_w),
    .empty       (empty_w),
    .group_ready (group_w)
  );

  dreq_len_ctrl #(.LEN_W(LEN_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (host_en_wr),
    .en_val   (host_en_val),
    .len_wr   (host_len_wr),
    .len_val  (host_len_val),
    .push_req (host_push),
    .pop_ok   (pop_ok),
    .en_out   (en_w),
    .len_out  (len_remaining),
    .err_out  (push_err)
  );

  assign dma_data   = 16'(head_w);
  assign dma_dreq   = group_w;
  assign fifo_full  = full_w;
  assign fifo_count = occ_w;
  assign xfer_en    = en_w;
endmodule

// File: rtl/dreq_bridge_chk.sv
module dreq_bridge_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LEN_W = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_en_wr,
  input logic             host_len_wr,
  input logic             host_push,
  input logic             dma_pop,
  input logic             dma_tc_zero,
  input logic             dma_dreq,
  input logic             fifo_full,
  input logic [CNT_W-1:0] fifo_count,
  input logic             xfer_en,
  input logic [LEN_W-1:0] len_remaining,
  input logic             push_err
);
  logic pop_acc;
  assign pop_acc = dma_pop && !dma_tc_zero && (fifo_count != '0);

  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pop_acc) |=> $stable(fifo_count));

  p_dreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_dreq |-> (fifo_count != '0 && fifo_count[1:0] == 2'b00));

  p_noen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && !xfer_en && !pop_acc) |=> (push_err && $stable(fifo_count)));

  p_len_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && !host_len_wr && len_remaining != '0)
      |=> (len_remaining == $past(len_remaining) - LEN_W'(1)));

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_acc && !host_len_wr && !host_en_wr && len_remaining == LEN_W'(1))
      |=> !xfer_en);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_pop && !pop_acc && !host_push && !host_len_wr)
      |=> ($stable(fifo_count) && $stable(len_remaining)));

  p_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && xfer_en && !fifo_full && pop_acc) |=> $stable(fifo_count));

  p_full_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && pop_acc) |=> !fifo_full);
endmodule

bind dreq_fifo_bridge dreq_bridge_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_en_wr    (host_en_wr),
  .host_len_wr   (host_len_wr),
  .host_push     (host_push),
  .dma_pop       (dma_pop),
  .dma_tc_zero   (dma_tc_zero),
  .dma_dreq      (dma_dreq),
  .fifo_full     (fifo_full),
  .fifo_count    (fifo_count),
  .xfer_en       (xfer_en),
  .len_remaining (len_remaining),
  .push_err      (push_err)
);

// File: tb/tb_dreq_fifo_bridge.sv
`timescale 1ns/1ps
module tb_dreq_fifo_bridge;
  localparam int DEPTH = 8;
  localparam int LEN_W = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             host_en_wr = 1'b0, host_en_val = 1'b0;
  logic             host_len_wr = 1'b0;
  logic [LEN_W-1:0] host_len_val = '0;
  logic             host_push = 1'b0;
  logic [15:0]      host_data = '0;
  logic             dma_pop = 1'b0, dma_tc_zero = 1'b0;
  logic [15:0]      dma_data;
  logic             dma_dreq, fifo_full, xfer_en, push_err;
  logic [CNT_W-1:0] fifo_count;
  logic [LEN_W-1:0] len_remaining;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dreq_fifo_bridge #(.DEPTH(DEPTH), .LEN_W(LEN_W)) dut (.*);

  typedef struct packed {
    logic        push;
    logic        pop;
    logic        tc0;
    logic [15:0] data;
    logic [3:0]  cnt;
    logic        dreq;
    logic        full;
    logic        hv;
    logic [15:0] head;
    logic [15:0] len;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,16'hA001, 4'd1,1'b0,1'b0,1'b1,16'hA001,16'd20},
    '{1'b1,1'b0,1'b0,16'hA002, 4'd2,1'b0,1'b0,1'b1,16'hA001,16'd20},
    '{1'b1,1'b0,1'b0,16'hA003, 4'd3,1'b0,1'b0,1'b1,16'hA001,16'd20},
    '{1'b1,1'b0,1'b0,16'hA004, 4'd4,1'b1,1'b0,1'b1,16'hA001,16'd20},
    '{1'b1,1'b1,1'b0,16'hA005, 4'd4,1'b1,1'b0,1'b1,16'hA002,16'd19},
    '{1'b0,1'b1,1'b0,16'h0000, 4'd3,1'b0,1'b0,1'b1,16'hA003,16'd18},
    '{1'b1,1'b0,1'b0,16'hA006, 4'd4,1'b1,1'b0,1'b1,16'hA003,16'd18},
    '{1'b1,1'b0,1'b0,16'hA007, 4'd5,1'b0,1'b0,1'b1,16'hA003,16'd18},
    '{1'b1,1'b0,1'b0,16'hA008, 4'd6,1'b0,1'b0,1'b1,16'hA003,16'd18},
    '{1'b1,1'b0,1'b0,16'hA009, 4'd7,1'b0,1'b0,1'b1,16'hA003,16'd18},
    '{1'b1,1'b0,1'b0,16'hA00A, 4'd8,1'b1,1'b1,1'b1,16'hA003,16'd18},
    '{1'b1,1'b0,1'b0,16'hA00B, 4'd8,1'b1,1'b1,1'b1,16'hA003,16'd18},
    '{1'b1,1'b1,1'b0,16'hA00C, 4'd7,1'b0,1'b0,1'b1,16'hA004,16'd17},
    '{1'b0,1'b1,1'b1,16'h0000, 4'd7,1'b0,1'b0,1'b1,16'hA004,16'd17},
    '{1'b0,1'b1,1'b0,16'h0000, 4'd6,1'b0,1'b0,1'b1,16'hA005,16'd16},
    '{1'b0,1'b1,1'b0,16'h0000, 4'd5,1'b0,1'b0,1'b1,16'hA006,16'd15},
    '{1'b0,1'b1,1'b0,16'h0000, 4'd4,1'b1,1'b0,1'b1,16'hA007,16'd14},
    '{1'b0,1'b1,1'b0,16'h0000, 4'd3,1'b0,1'b0,1'b1,16'hA008,16'd13},
    '{1'b0,1'b1,1'b0,16'h0000, 4'd2,1'b0,1'b0,1'b1,16'hA009,16'd12},
    '{1'b0,1'b1,1'b0,16'h0000, 4'd1,1'b0,1'b0,1'b1,16'hA00A,16'd11},
    '{1'b0,1'b1,1'b0,16'h0000, 4'd0,1'b0,1'b0,1'b0,16'h0000,16'd10},
    '{1'b0,1'b1,1'b0,16'h0000, 4'd0,1'b0,1'b0,1'b0,16'h0000,16'd10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at falling edge, one rising edge passes, return at next falling edge
  task automatic step(input logic push, input logic pop, input logic tc0, input logic [15:0] d);
    host_push = push; dma_pop = pop; dma_tc_zero = tc0; host_data = d;
    @(negedge clk);
    host_push = 1'b0; dma_pop = 1'b0; dma_tc_zero = 1'b0; host_data = '0;
  endtask

  task automatic set_en(input logic v);
    host_en_wr = 1'b1; host_en_val = v;
    @(negedge clk);
    host_en_wr = 1'b0;
  endtask

  task automatic set_len(input logic [LEN_W-1:0] v);
    host_len_wr = 1'b1; host_len_val = v;
    @(negedge clk);
    host_len_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(fifo_count), 0);
    chk("R1 len", 32'(len_remaining), 0);
    chk("R1 en", 32'(xfer_en), 0);
    chk("R1 full", 32'(fifo_full), 0);
    chk("R1 dreq", 32'(dma_dreq), 0);
    chk("R1 err", 32'(push_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 push while disabled
    step(1'b1, 1'b0, 1'b0, 16'hBEEF);
    chk("R2 count unchanged", 32'(fifo_count), 0);
    chk("R2 err pulse", 32'(push_err), 1);
    step(1'b0, 1'b0, 1'b0, 16'h0);
    chk("R2 err one cycle", 32'(push_err), 0);

    // R6 length load, enable
    set_len(16'd20);
    chk("R6 len load", 32'(len_remaining), 20);
    set_en(1'b1);
    chk("R7 en set", 32'(xfer_en), 1);

    // table walk: R3 R4 R5 R6 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].push, TBL[i].pop, TBL[i].tc0, TBL[i].data);
      chk($sformatf("R3/R9 count row%0d", i), 32'(fifo_count), 32'(TBL[i].cnt));
      chk($sformatf("R4 dreq row%0d", i), 32'(dma_dreq), 32'(TBL[i].dreq));
      chk($sformatf("R3/R10 full row%0d", i), 32'(fifo_full), 32'(TBL[i].full));
      chk($sformatf("R6/R8 len row%0d", i), 32'(len_remaining), 32'(TBL[i].len));
      if (TBL[i].hv)
        chk($sformatf("R5 head row%0d", i), 32'(dma_data), 32'(TBL[i].head));
    end
    chk("R2 no err while enabled", 32'(push_err), 0);

    // R7 completion clears enable
    set_len(16'd2);
    step(1'b1, 1'b0, 1'b0, 16'hC001);
    step(1'b1, 1'b0, 1'b0, 16'hC002);
    step(1'b0, 1'b1, 1'b0, 16'h0);
    chk("R7 en still set", 32'(xfer_en), 1);
    chk("R6 len one", 32'(len_remaining), 1);
    chk("R5 head second", 32'(dma_data), 32'h0000C002);
    step(1'b0, 1'b1, 1'b0, 16'h0);
    chk("R7 en cleared", 32'(xfer_en), 0);
    chk("R7 len zero", 32'(len_remaining), 0);
    chk("R8 empty", 32'(fifo_count), 0);
    step(1'b1, 1'b0, 1'b0, 16'hC003);
    chk("R2 refused after done", 32'(fifo_count), 0);
    chk("R2 err after done", 32'(push_err), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule